// File: doc/BRIEF.md
# Multi-Mode Programmable Divider

This block is a programmable down-counter built around a 16-bit divisor. Software writes the divisor one byte at a time over a small register bus. It then issues start and stop commands. The selected mode decides what the count produces:

- **Square-wave mode** gives a continuous square wave. It also gives a one-cycle enable pulse that a serial engine can use as its 16x bit clock.
- **Delay mode** gives one delay and then raises a sticky completion flag.
- **Gap mode** watches for silence between received characters. Each character strobe restarts the count. If the count runs out, the same flag reports a timeout.

The current count can be read back over the same bus. A divisor below 2 is reported on a status pin and replaced by 2. A new divisor written during a count is used only at the next load, so the interval in progress keeps its length.

Top module: `ctmr_top`

## Requirements
- R1: Bus address 0 holds the low divisor byte and address 1 holds the high byte. A cycle with `bus_wr` high writes `bus_wdata` into the addressed byte, and `bus_rdata` shows the addressed byte in the same cycle. After reset the divisor is 2 (low byte 0x02, high byte 0x00).
- R2: Address 2 reads the low byte of the current count and address 3 reads the high byte. Writes to these addresses change nothing.
- R3: With `mode_sel` = 0 (square wave), a start sampled at clock edge S loads the divisor n. `tmr_out` then inverts at edges S+n, S+2n, S+3n and so on, which gives a period of 2n clocks.
- R4: `baud_en` is high for exactly the one cycle after each inversion of `tmr_out`. It never pulses in the other modes.
- R5: With `mode_sel` = 1 (delay), a start at edge S raises `tc_flag` at edge S+n. The count then stays at 0, and the flag stays high until a start or a stop.
- R6: With `mode_sel[1]` = 1 (gap), a start arms the block and begins a count. Each `rx_char` strobe while armed clears `tc_flag` and reloads the count. `tc_flag` rises n edges after the last start or strobe. `rx_char` has no effect in modes 0 and 1.
- R7: A stop command freezes the count and `tmr_out`, clears `tc_flag`, and disarms gap mode. If start and stop are high in the same cycle, stop takes priority.
- R8: A divisor of 0 or 1 drives `div_bad` high, and the block counts as though the divisor were 2.
- R9: A divisor write during a count does not change the interval in progress. The new value applies at the next start, strobe reload or square-wave reload.
- R10: After reset, `tmr_out`, `baud_en` and `tc_flag` are 0 and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 square wave, 1 delay, 2 or 3 gap timeout |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| rx_char | input | 1 | Received-character strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| tmr_out | output | 1 | Square-wave output |
| baud_en | output | 1 | One-cycle pulse at each square-wave inversion |
| tc_flag | output | 1 | Delay done or gap timeout flag |
| div_bad | output | 1 | Divisor is 0 or 1 |

## Verification
The bench builds the block with its default parameters: two 8-bit divisor bytes and a reset divisor of 2. With these values, small divisors give many square-wave inversions in a short run. A delay of 258 clocks is used so that both bytes are exercised and the high byte carries real weight. Stop is issued at a known edge, so the frozen count read over the bus can be predicted exactly.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam logic [1:0] MODE_SQUARE = 2'd0;
  localparam logic [1:0] MODE_DELAY  = 2'd1;

  function automatic logic is_gap(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic is_square(input logic [1:0] m);
    return m == MODE_SQUARE;
  endfunction
endpackage

// File: rtl/ctmr_divreg.sv
module ctmr_divreg #(
  parameter int BYTE_W    = 8,
  parameter int NBYTES    = 2,
  parameter int RESET_DIV = 2,
  localparam int CNT_W    = BYTE_W * NBYTES,
  localparam int ADDR_W   = $clog2(2 * NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  div_raw,
  output logic [CNT_W-1:0]  load_val,
  output logic              bad
);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_DIV);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(2);

  logic [BYTE_W-1:0] byte_q [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        byte_q[b] <= RST_V[b*BYTE_W +: BYTE_W];
      else if (wr && addr == ADDR_W'(b))
        byte_q[b] <= wdata;
    end
    assign div_raw[b*BYTE_W +: BYTE_W] = byte_q[b];
  end

  always_comb begin
    bad      = div_raw < MIN_V;
    load_val = bad ? MIN_V : div_raw;
  end
endmodule

// File: rtl/ctmr_rdmux.sv
module ctmr_rdmux #(
  parameter int BYTE_W  = 8,
  parameter int NBYTES  = 2,
  localparam int CNT_W  = BYTE_W * NBYTES,
  localparam int ADDR_W = $clog2(2 * NBYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  div_raw,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == ADDR_W'(b))          rdata = div_raw[b*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(NBYTES + b)) rdata = cnt[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             start,
  input  logic             stop,
  input  logic             rx_char,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             sq_out,
  output logic             pulse,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic armed;
  logic at_tc;
  logic gap_reload;

  assign at_tc      = run && (cnt == ONE);
  assign gap_reload = is_gap(mode) && rx_char && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      run    <= 1'b0;
      armed  <= 1'b0;
      sq_out <= 1'b0;
      pulse  <= 1'b0;
      flag   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (stop) begin
        run   <= 1'b0;
        armed <= 1'b0;
        flag  <= 1'b0;
      end else if (start) begin
        cnt   <= load_val;
        run   <= 1'b1;
        armed <= 1'b1;
        flag  <= 1'b0;
      end else if (gap_reload) begin
        cnt  <= load_val;
        run  <= 1'b1;
        flag <= 1'b0;
      end else if (at_tc) begin
        if (is_square(mode)) begin
          cnt    <= load_val;
          sq_out <= ~sq_out;
          pulse  <= 1'b1;
        end else begin
          cnt  <= '0;
          run  <= 1'b0;
          flag <= 1'b1;
        end
      end else if (run) begin
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top #(
  parameter int BYTE_W    = 8,
  parameter int NBYTES    = 2,
  parameter int RESET_DIV = 2,
  localparam int CNT_W    = BYTE_W * NBYTES,
  localparam int ADDR_W   = $clog2(2 * NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              rx_char,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              tmr_out,
  output logic              baud_en,
  output logic              tc_flag,
  output logic              div_bad
);
  logic [CNT_W-1:0] div_raw;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_w;
  logic             run_w;

  ctmr_divreg #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .RESET_DIV(RESET_DIV)) u_divreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .div_raw (div_raw),
    .load_val(load_val),
    .bad     (div_bad)
  );

  ctmr_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_sel),
    .start   (cmd_start),
    .stop    (cmd_stop),
    .rx_char (rx_char),
    .load_val(load_val),
    .cnt     (cnt_w),
    .run     (run_w),
    .sq_out  (tmr_out),
    .pulse   (baud_en),
    .flag    (tc_flag)
  );

  ctmr_rdmux #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_rdmux (
    .addr   (bus_addr),
    .div_raw(div_raw),
    .cnt    (cnt_w),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic             cmd_stop,
  input logic             tmr_out,
  input logic             baud_en,
  input logic             tc_flag,
  input logic             div_bad,
  input logic [CNT_W-1:0] cnt,
  input logic             run
);
  // R4: an inversion of the square wave always comes with the enable pulse
  assert_toggle_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tmr_out) |-> baud_en);

  // R4: the pulse only follows a square-wave-mode cycle
  assert_pulse_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |-> $past(mode_sel) == 2'd0);

  // R7: stop clears the flag and freezes the output
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !tc_flag);
  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> $stable(tmr_out));

  // R5: the flag rises only out of terminal count
  assert_flag_from_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(cnt) == CNT_W'(1));

  // R8: a running count never reaches zero, so the clamp keeps the divisor legal
  assert_run_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt != '0);
endmodule

bind ctmr_top ctmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_sel(mode_sel),
  .cmd_stop(cmd_stop),
  .tmr_out (tmr_out),
  .baud_en (baud_en),
  .tc_flag (tc_flag),
  .div_bad (div_bad),
  .cnt     (cnt_w),
  .run     (run_w)
);

// File: tb/test_ctmr_top.sv
`timescale 1ns/1ps
module test_ctmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       cmd_start = 1'b0, cmd_stop = 1'b0, rx_char = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmr_out, baud_en, tc_flag, div_bad;

  int checks = 0, fails = 0;
  int cyc = 0;
  int tog_q[$];
  int flg_q[$];
  logic prev_out = 1'b0, prev_flag = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctmr_top i_ctmr_top (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .rx_char(rx_char), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_out(tmr_out),
    .baud_en(baud_en), .tc_flag(tc_flag), .div_bad(div_bad)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: compares observed events against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (tmr_out !== prev_out) begin
        if (tog_q.size() == 0) chk("R3 unexpected toggle", cyc, -1);
        else chk("R3 toggle cycle", cyc, tog_q.pop_front());
        chk("R4 pulse with toggle", int'(baud_en), 1);
      end else if (baud_en) begin
        chk("R4 pulse without toggle", 1, 0);
      end
      if (tc_flag && !prev_flag) begin
        if (flg_q.size() == 0) chk("R5/R6 unexpected flag", cyc, -1);
        else chk("R5/R6 flag cycle", cyc, flg_q.pop_front());
      end
    end
    prev_out  = tmr_out;
    prev_flag = tc_flag;
  end

  task automatic edge_done(); @(posedge clk); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    edge_done(); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    chk(req, int'(bus_rdata), exp);
  endtask

  task automatic start(output int s);
    @(negedge clk); cmd_start = 1'b1; edge_done(); cmd_start = 1'b0; s = cyc;
  endtask

  task automatic stop(output int s);
    @(negedge clk); cmd_stop = 1'b1; edge_done(); cmd_stop = 1'b0; s = cyc;
  endtask

  task automatic rx(output int s);
    @(negedge clk); rx_char = 1'b1; edge_done(); rx_char = 1'b0; s = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) edge_done();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int s, t, r, held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10 reset state, R1 reset divisor
    @(negedge clk);
    chk("R10 tmr_out", int'(tmr_out), 0);
    chk("R10 tc_flag", int'(tc_flag), 0);
    chk("R10 baud_en", int'(baud_en), 0);
    rd(2'd2, 0, "R10 count lo");
    rd(2'd3, 0, "R10 count hi");
    rd(2'd0, 2, "R1 reset div lo");
    rd(2'd1, 0, "R1 reset div hi");

    // R3/R4/R7 square wave, n=5
    wr(2'd0, 8'd5);
    wr(2'd2, 8'hAA); // R2 write to count address ignored
    rd(2'd0, 5, "R1 readback lo");
    rd(2'd2, 0, "R2 count unchanged by write");
    mode_sel = 2'd0;
    start(s);
    for (int k = 1; k <= 4; k++) tog_q.push_back(s + 5 * k);
    wait_until(s + 21);
    stop(t);                      // edge s+22, count held at 4
    rd(2'd2, 4, "R7 frozen count");
    chk("R7 output after 4 toggles", int'(tmr_out), 0);
    repeat (10) edge_done();
    rd(2'd2, 4, "R7 count still frozen");
    chk("R3 all toggles seen", tog_q.size(), 0);

    // R5 delay, n=258, R6 rx ignored in delay mode
    wr(2'd0, 8'h02); wr(2'd1, 8'h01);
    rd(2'd1, 1, "R1 readback hi");
    mode_sel = 2'd1;
    start(s);
    flg_q.push_back(s + 258);
    wait_until(s + 99);
    rx(r);
    wait_until(s + 270);
    chk("R5 flag sticky", int'(tc_flag), 1);
    chk("R6 rx ignored in delay", flg_q.size(), 0);
    rd(2'd2, 0, "R5 count at zero");
    stop(t);
    @(negedge clk);
    chk("R7 stop clears flag", int'(tc_flag), 0);

    // R7 stop frozen mid-count: n=20 delay mode, stop at edge s+7 -> 14
    wr(2'd0, 8'd20); wr(2'd1, 8'd0);
    start(s);
    repeat (6) edge_done();
    stop(t);
    rd(2'd2, 14, "R7 mid-count freeze");

    // R8 illegal divisor
    wr(2'd0, 8'd0);
    @(negedge clk); chk("R8 div 0 bad", int'(div_bad), 1);
    mode_sel = 2'd0;
    start(s);
    for (int k = 1; k <= 3; k++) tog_q.push_back(s + 2 * k);
    wait_until(s + 6);
    stop(t);
    wr(2'd0, 8'd1);
    @(negedge clk); chk("R8 div 1 bad", int'(div_bad), 1);
    wr(2'd0, 8'd3);
    @(negedge clk); chk("R8 div 3 legal", int'(div_bad), 0);

    // R9 write mid-count: n=4 then 7
    wr(2'd0, 8'd4);
    start(s);
    tog_q.push_back(s + 4);
    tog_q.push_back(s + 11);
    wr(2'd0, 8'd7);
    wait_until(s + 12);
    stop(t);
    chk("R9 toggles seen", tog_q.size(), 0);

    // R6 gap timeout, n=6
    wr(2'd0, 8'd6);
    mode_sel = 2'd2;
    start(s);
    wait_until(s + 3); rx(r);
    wait_until(r + 3); rx(r);
    wait_until(r + 3); rx(r);
    flg_q.push_back(r + 6);
    wait_until(r + 9);
    chk("R6 timeout flag", int'(tc_flag), 1);
    mode_sel = 2'd3;
    rx(r);
    @(negedge clk);
    chk("R6 rx clears flag", int'(tc_flag), 0);
    flg_q.push_back(r + 6);
    wait_until(r + 8);
    chk("R6 rearmed timeout", int'(tc_flag), 1);
    stop(t);
    rx(r);                        // disarmed: ignored
    held = int'(tc_flag);
    repeat (8) edge_done();
    chk("R7 disarmed gap ignores rx", int'(tc_flag), held);
    chk("R6 all flags seen", flg_q.size(), 0);

    // R7 stop beats start
    @(negedge clk); cmd_start = 1'b1; cmd_stop = 1'b1;
    edge_done(); cmd_start = 1'b0; cmd_stop = 1'b0;
    repeat (3) edge_done();
    rd(2'd2, 0, "R7 stop priority");

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule